// File: doc/BRIEF.md
# Addressable Output Latch Driver

This block holds eight switch states for relay, lamp or LED drivers. On each rising clock edge it samples a binary select, one data bit, an active-low enable and an active-low clear. From those inputs it updates one addressed switch, holds all switches, forces every switch off, or routes the data bit to a single switch while the others are off. The last of these is the demultiplex mode.

The outputs model open-collector switches. A low output means the load is ON. A data bit of 1 therefore pulls the addressed output low.

An active-low asynchronous reset models power-on clear and brings every output up OFF. The storage is a bank of flip-flops with a synchronous mode decode, not transparent latches. A result therefore appears at the outputs just after the clock edge that sampled it.

Top module: `addr_latch_driver`

## Requirements
- R1: While `rst_n` is low, every bit of `out_n` is 1 (OFF), with or without a clock edge.
- R2: A clock edge with `en_n`=1 and `clr_n`=1 leaves `out_n` unchanged, whatever `sel` and `data_in` carry.
- R3: A clock edge with `en_n`=0 and `clr_n`=1 sets `out_n[sel]` to the inverse of `data_in` and leaves every other bit unchanged.
- R4: A clock edge with `en_n`=1 and `clr_n`=0 sets every bit of `out_n` to 1.
- R5: A clock edge with `en_n`=0 and `clr_n`=0 sets `out_n[sel]` to the inverse of `data_in` and every other bit to 1. A data bit of 1 thus overrides the clear on the addressed output only.
- R6: Changes on `sel`, `data_in`, `en_n` or `clr_n` between clock edges do not alter `out_n`. The outputs change only on a rising edge of `clk`, or on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| rst_n | input | 1 | Asynchronous power-on clear, active low |
| sel | input | ADDR_W | Binary index of the addressed output |
| data_in | input | 1 | 1 turns the addressed switch ON, 0 turns it OFF |
| en_n | input | 1 | Enable, active low |
| clr_n | input | 1 | Clear, active low |
| out_n | output | 2**ADDR_W | Switch outputs, low means ON |

## Verification
The assertions assume that `sel`, `data_in`, `en_n` and `clr_n` are synchronous to `clk` and hold known values at each rising edge. They also assume that `rst_n` is released away from a clock edge. The bench changes every input only on the falling edge and releases reset on a falling edge. This gives the design half a period of setup and hold. The bench also drives an asynchronous reset partway through a cycle, so that the power-on clear is observed without a clock edge.

// File: rtl/addr_latch_driver.sv
module addr_latch_driver #(
  parameter int ADDR_W = 3,
  localparam int N = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] sel,
  input  logic              data_in,
  input  logic              en_n,
  input  logic              clr_n,
  output logic [N-1:0]      out_n
);
  logic [N-1:0] on_q, on_d, hit;

  assign hit = {{(N-1){1'b0}}, 1'b1} << sel;

  always_comb begin
    case ({clr_n, en_n})
      2'b11:   on_d = on_q;
      2'b10:   on_d = (on_q & ~hit) | (data_in ? hit : '0);
      2'b01:   on_d = '0;
      default: on_d = data_in ? hit : '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) on_q <= '0;
    else        on_q <= on_d;

  // outputs are open-collector style: low = ON
  assign out_n = ~on_q;
endmodule

// File: rtl/addr_latch_driver_chk.sv
module addr_latch_driver_chk #(
  parameter int ADDR_W = 3,
  localparam int N = 1 << ADDR_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] sel,
  input logic              data_in,
  input logic              en_n,
  input logic              clr_n,
  input logic [N-1:0]      out_n
);
  logic [N-1:0] sel_mask;
  assign sel_mask = {{(N-1){1'b0}}, 1'b1} << sel;

  always @(posedge clk)
    if (!rst_n) a_r1_reset_off: assert (out_n == '1);

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en_n && clr_n) |=> $stable(out_n));

  a_r3_others_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_n && clr_n) |=> (((out_n ^ $past(out_n)) & ~$past(sel_mask)) == '0));

  a_r3_addressed: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_n && clr_n) |=> ((out_n & $past(sel_mask)) == ($past(data_in) ? '0 : $past(sel_mask))));

  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (en_n && !clr_n) |=> (out_n == '1));

  a_r5_demux: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_n && !clr_n) |=> (out_n == ($past(data_in) ? ~$past(sel_mask) : '1)));
endmodule

bind addr_latch_driver addr_latch_driver_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .data_in(data_in),
  .en_n(en_n), .clr_n(clr_n), .out_n(out_n)
);

// File: tb/addr_latch_driver_tb.sv
module addr_latch_driver_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 3;
  localparam int N = 1 << AW;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          rst_n = 1'b0;
  logic [AW-1:0] sel = '0;
  logic          data_in = 1'b0;
  logic          en_n = 1'b1;
  logic          clr_n = 1'b1;
  logic [N-1:0]  out_n;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [N-1:0] ref_on = '0;

  addr_latch_driver #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .data_in(data_in),
    .en_n(en_n), .clr_n(clr_n), .out_n(out_n)
  );

  task automatic check(string req, logic [N-1:0] exp);
    checks++;
    if (out_n !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, out_n, exp);
    end
  endtask

  // drive one operation on a falling edge, confirm nothing moves before the
  // rising edge (R6), then compare with the model after the edge
  task automatic apply(logic c, logic e, int a, logic d, string req);
    @(negedge clk);
    clr_n = c; en_n = e; sel = AW'(a); data_in = d;
    #1 check("R6", ~ref_on);
    @(posedge clk);
    if (!c && !e) begin ref_on = '0; ref_on[a] = d; end
    else if (!c)  ref_on = '0;
    else if (!e)  ref_on[a] = d;
    @(negedge clk);
    check(req, ~ref_on);
    clr_n = 1'b1; en_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 2 + 2);
    check("R1", '1);
    @(negedge clk); rst_n = 1'b1;

    // R3: switch every output ON in turn, then OFF on odd addresses
    for (int a = 0; a < N; a++) apply(1'b1, 1'b0, a, 1'b1, "R3");
    for (int a = 1; a < N; a += 2) apply(1'b1, 1'b0, a, 1'b0, "R3");

    // R2: hold with random address and data
    for (int i = 0; i < 16; i++) apply(1'b1, 1'b1, $urandom_range(N-1), 1'($urandom), "R2");

    // R4: clear at each address with data high
    for (int a = 0; a < N; a++) begin
      apply(1'b1, 1'b0, (a + 3) % N, 1'b1, "R3");
      apply(1'b0, 1'b1, a, 1'b1, "R4");
    end

    // R5: demultiplex every address with both data values, from a busy state
    for (int a = 0; a < N; a++) begin
      for (int b = 0; b < N; b += 2) apply(1'b1, 1'b0, b, 1'b1, "R3");
      apply(1'b0, 1'b0, a, 1'b1, "R5");
      apply(1'b0, 1'b0, a, 1'b0, "R5");
    end

    // random mix of all modes
    for (int i = 0; i < 200; i++)
      apply(1'($urandom), 1'($urandom), $urandom_range(N-1), 1'($urandom), "R2-R5 mix");

    // R1: asynchronous clear mid-cycle with no clock edge
    for (int a = 0; a < N; a++) apply(1'b1, 1'b0, a, 1'b1, "R3");
    @(negedge clk);
    #2 rst_n = 1'b0;
    #1 check("R1", '1);
    ref_on = '0;
    @(negedge clk); rst_n = 1'b1;
    apply(1'b1, 1'b0, 5, 1'b1, "R3");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule